// File: doc/BRIEF.md
# Shared Interrupt Aggregator

This block gathers a wide set of level-high peripheral interrupt lines into sticky pending bits, arranged as 32-bit status words. It concentrates them onto a small number of shared CPU interrupt lines. Each CPU line has a private bank of enable words, with one enable word for each status word. A CPU line requests service when some pending source is enabled in its bank and the line's master enable is on. The master enable is bit 0 of that bank's first enable word. Software acknowledges sources by writing ones to a clear word.

Each CPU line is provided in two forms: a registered level and a one-cycle pulse that fires on the level's rising edge. The CPU side is edge-sensitive, so the pulse is the signal it relies on. Software can force a new pulse while enabled work is still pending by turning the master enable off and then on again. Registers are reached through a simple synchronous bus. Reads return data combinationally in the cycle of the access. Writes take effect at the clock edge of the access.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every pending bit, every enable bit, every level output and every pulse output is 0.
- R2: A source held high at a rising clock edge sets its pending bit, which stays set after the source drops. Source index w*32+n appears as bit n of the status word at byte address 0x00+4*w, whether or not the source is enabled.
- R3: A write to the clear word at 0x08+4*w clears each pending bit of word w whose data bit is 1. Pending bits under 0 data bits keep their value.
- R4: If a source is high in the same cycle as a clear write to its bit, the pending bit remains set.
- R5: Enable word w of output g is read and written at byte address 0x10+8*g+4*w. A write takes effect at the clock edge of the access.
- R6: The level of output g is the registered value, one edge later, of the OR over all words of (status AND enable word of g), ANDed with bit 0 of enable word 0 of g. That bit is both the master enable and the enable for source 0.
- R7: The pulse of output g is high for exactly one cycle, in the same cycle that the level of g rises.
- R8: If enabled sources are still pending, clearing and then setting the master enable drops the level and then produces a new pulse.
- R9: A pending source that is disabled is delivered as soon as its enable bit is set, unless it has been cleared first.
- R10: Each output's enable bank acts only on that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| src_i | input | 64 | Level-high interrupt sources |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_level_o | output | 4 | Gated request level for each output |
| irq_pulse_o | output | 4 | One-cycle rising-edge pulse for each output |

## Verification
A source is captured at the first edge at which it is high, and the status word is readable right after that edge. The level and pulse outputs follow one edge later. A register write or clear changes state at its own edge, so a change to an enable reaches the outputs at the following edge. The bench drives and samples on the falling edge and counts rising edges between stimulus and check to match these delays. This lets it confirm the single-cycle width of each pulse at the next falling edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int IRQ_WORD_W = 32;
  typedef logic [IRQ_WORD_W-1:0] irq_word_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank
  import irq_agg_pkg::*;
#(
  parameter int NW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  irq_word_t [NW-1:0]  src,
  input  logic      [NW-1:0]  clr_hit,
  input  irq_word_t           clr_data,
  output irq_word_t [NW-1:0]  pend_q
);
  irq_word_t [NW-1:0] pend_d;
  irq_word_t [NW-1:0] clr_mask;

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      clr_mask[w] = clr_hit[w] ? clr_data : '0;
      // set beats clear so no event is lost
      pend_d[w]   = (pend_q[w] & ~clr_mask[w]) | src[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar w = 0; w < NW; w++) begin : g_chk
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_q[w]) & ~$past(clr_mask[w])) & ~pend_q[w]) == '0));
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(src[w]) & ~pend_q[w]) == '0));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q[w] & $past(clr_mask[w]) & ~$past(src[w])) == '0));
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_agg_pkg::*;
#(
  parameter int NW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic      [NW-1:0]  wr_hit,
  input  irq_word_t           wdata,
  output irq_word_t [NW-1:0]  en_q
);
  irq_word_t [NW-1:0] en_d;

  always_comb begin
    en_d = en_q;
    for (int w = 0; w < NW; w++) begin
      if (wr_hit[w]) en_d[w] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  for (genvar w = 0; w < NW; w++) begin : g_chk
    p_en_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[w] |=> (en_q[w] == $past(wdata)));
    p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[w] |=> $stable(en_q[w]));
  end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import irq_agg_pkg::*;
#(
  parameter int NW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  irq_word_t [NW-1:0]  pend,
  input  irq_word_t [NW-1:0]  en,
  output logic                level_q,
  output logic                pulse_q
);
  logic any_hit;
  logic req;
  logic level_d;
  logic pulse_d;

  always_comb begin
    any_hit = 1'b0;
    for (int w = 0; w < NW; w++) begin
      any_hit = any_hit | (|(pend[w] & en[w]));
    end
    req     = any_hit & en[0][0];
    level_d = req;
    pulse_d = req & ~level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      level_q <= level_d;
      pulse_q <= pulse_d;
    end
  end

  p_master_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0][0] |=> !level_q);
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_pulse_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_q) |-> pulse_q);
  p_pulse_needs_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> level_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_OUT = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_OUT-1:0] irq_level_o,
  output logic [NUM_OUT-1:0] irq_pulse_o
);
  localparam int NW        = NUM_SRC / IRQ_WORD_W;
  localparam int IDX_W     = ADDR_W - 2;
  localparam int STAT_BASE = 0;
  localparam int CLR_BASE  = NW;
  localparam int EN_BASE   = 2 * NW;

  logic               rst_s_n;
  logic [IDX_W-1:0]   idx;
  logic               addr_ok;
  logic               wr_go;
  irq_word_t [NW-1:0] src_w;
  irq_word_t [NW-1:0] pend;
  logic      [NW-1:0] clr_hit;
  irq_word_t [NW-1:0] en_all [NUM_OUT];
  logic      [NW-1:0] en_hit [NUM_OUT];

  assign idx     = bus_addr[ADDR_W-1:2];
  assign addr_ok = (bus_addr[1:0] == 2'b00);
  assign wr_go   = bus_sel & bus_wr & addr_ok;
  assign src_w   = src_i;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  for (genvar w = 0; w < NW; w++) begin : g_clr
    assign clr_hit[w] = wr_go & (idx == IDX_W'(CLR_BASE + w));
  end

  irq_pending_bank #(.NW(NW)) u_pend (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .src      (src_w),
    .clr_hit  (clr_hit),
    .clr_data (bus_wdata),
    .pend_q   (pend)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    for (genvar w = 0; w < NW; w++) begin : g_hit
      assign en_hit[g][w] = wr_go & (idx == IDX_W'(EN_BASE + g * NW + w));
    end

    irq_enable_bank #(.NW(NW)) u_en (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .wr_hit (en_hit[g]),
      .wdata  (bus_wdata),
      .en_q   (en_all[g])
    );

    irq_line_gen #(.NW(NW)) u_line (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .pend    (pend),
      .en      (en_all[g]),
      .level_q (irq_level_o[g]),
      .pulse_q (irq_pulse_o[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && addr_ok) begin
      for (int w = 0; w < NW; w++) begin
        if (idx == IDX_W'(STAT_BASE + w)) bus_rdata = pend[w];
      end
      for (int g = 0; g < NUM_OUT; g++) begin
        for (int w = 0; w < NW; w++) begin
          if (idx == IDX_W'(EN_BASE + g * NW + w)) bus_rdata = en_all[g][w];
        end
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (irq_level_o == '0 && irq_pulse_o == '0));
  p_pulse_onehot_src_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones(irq_pulse_o & ~irq_level_o) == 0);
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_level_o;
  logic [3:0]  irq_pulse_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_level_o (irq_level_o),
    .irq_pulse_o (irq_pulse_o)
  );

  typedef struct packed {
    logic [63:0] src;
    logic [31:0] e0;
    logic [31:0] e1;
    logic        lvl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{64'h0000_0000_0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b1},
    '{64'h0000_0100_0000_0000, 32'h0000_0001, 32'h0000_0100, 1'b1},
    '{64'h0000_0100_0000_0000, 32'h0000_0001, 32'h0000_0000, 1'b0},
    '{64'h0000_0100_0000_0000, 32'h0000_0000, 32'h0000_0100, 1'b0},
    '{64'h0000_0002_0000_0080, 32'h0000_0081, 32'h0000_0000, 1'b1},
    '{64'h0000_0000_0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic src_pulse(input logic [63:0] p);
    @(negedge clk);
    src_i = p;
    @(negedge clk);
    src_i = '0;
  endtask

  task automatic clear_all();
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_write(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 level", 64'(irq_level_o), 64'h0);
    chk("R1 pulse", 64'(irq_pulse_o), 64'h0);
    bus_read(8'h00, rd); chk("R1 status0", 64'(rd), 64'h0);
    bus_read(8'h04, rd); chk("R1 status1", 64'(rd), 64'h0);
    bus_read(8'h10, rd); chk("R1 enable", 64'(rd), 64'h0);

    // table-driven: R2 status mapping, R6 gated level, R7 pulse on output 0
    foreach (VECS[i]) begin
      bus_write(8'h10, 32'h0);
      bus_write(8'h14, 32'h0);
      clear_all();
      repeat (2) @(negedge clk);
      bus_write(8'h10, VECS[i].e0);
      bus_write(8'h14, VECS[i].e1);
      src_pulse(VECS[i].src);
      @(negedge clk);
      chk("R6 level", 64'(irq_level_o[0]), 64'(VECS[i].lvl));
      chk("R7 pulse", 64'(irq_pulse_o[0]), 64'(VECS[i].lvl));
      bus_read(8'h00, rd); chk("R2 status0", 64'(rd), 64'(VECS[i].src[31:0]));
      bus_read(8'h04, rd); chk("R2 status1", 64'(rd), 64'(VECS[i].src[63:32]));
    end

    // R8 master toggle regenerates a pulse
    bus_write(8'h10, 32'h0);
    bus_write(8'h14, 32'h0);
    clear_all();
    repeat (2) @(negedge clk);
    bus_write(8'h10, 32'h1);
    bus_write(8'h14, 32'h100);
    src_pulse(64'h0000_0100_0000_0000);
    @(negedge clk);
    chk("R7 pulse rise", 64'(irq_pulse_o[0]), 64'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", 64'(irq_pulse_o[0]), 64'h0);
    chk("R7 level held", 64'(irq_level_o[0]), 64'h1);
    bus_write(8'h10, 32'h0);
    @(negedge clk);
    chk("R8 level drops", 64'(irq_level_o[0]), 64'h0);
    bus_write(8'h10, 32'h1);
    @(negedge clk);
    chk("R8 new level", 64'(irq_level_o[0]), 64'h1);
    chk("R8 new pulse", 64'(irq_pulse_o[0]), 64'h1);

    // R9 disabled pending is kept and delivered on enable
    bus_write(8'h14, 32'h0);
    repeat (2) @(negedge clk);
    chk("R9 masked level", 64'(irq_level_o[0]), 64'h0);
    bus_read(8'h04, rd); chk("R9 still pending", 64'(rd), 64'h100);
    bus_write(8'h14, 32'h100);
    @(negedge clk);
    chk("R9 delivered", 64'(irq_level_o[0]), 64'h1);
    bus_write(8'h14, 32'h0);
    bus_write(8'h0C, 32'h100);
    bus_write(8'h14, 32'h100);
    @(negedge clk);
    chk("R9 cleared not delivered", 64'(irq_level_o[0]), 64'h0);

    // R3 partial clear
    bus_write(8'h10, 32'h0);
    bus_write(8'h14, 32'h0);
    clear_all();
    src_pulse(64'hFF);
    bus_write(8'h08, 32'h0F);
    bus_read(8'h00, rd); chk("R3 partial clear", 64'(rd), 64'hF0);

    // R4 set beats clear in the same cycle
    clear_all();
    @(negedge clk);
    src_i = 64'h20;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h20;
    @(negedge clk);
    src_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(8'h00, rd); chk("R4 set wins", 64'(rd), 64'h20);

    // R10 independence and R5 address map
    clear_all();
    repeat (2) @(negedge clk);
    bus_write(8'h20, 32'h1);
    src_pulse(64'h1);
    @(negedge clk);
    chk("R10 only output 2", 64'(irq_level_o), 64'h4);
    bus_read(8'h20, rd); chk("R5 readback out2 w0", 64'(rd), 64'h1);
    bus_write(8'h24, 32'hA5A5_0000);
    bus_read(8'h24, rd); chk("R5 readback out2 w1", 64'(rd), 64'hA5A5_0000);
    bus_read(8'h1C, rd); chk("R5 out1 w1 untouched", 64'(rd), 64'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule